// File: doc/BRIEF.md
# Oscillator Frequency-Lock Calibrator

This block trims an on-chip RC oscillator while it runs. It is clocked by the oscillator it calibrates. Two slow 32.768 kHz reference inputs, one from a calibrated internal source and one from a crystal, are sampled into that clock domain. The selected reference is divided by 32 to give a 1.024 kHz measurement window. Over each window the block counts oscillator cycles and compares the count with a programmable target: about 1953 for a 2 MHz oscillator and 31250 for a 32 MHz one. It then moves a calibration code one step towards the target. A chip carries one instance per oscillator, and each instance picks its reference on its own.

A four-state machine sequences the work:
- `ST_IDLE`: the block is disabled.
- `ST_ARM`: the first, partial window is being thrown away.
- `ST_COUNT`: a full window is being counted.
- `ST_ADJUST`: one cycle in which the code is stepped.

The transitions are:
- IDLE→ARM when enabled.
- ARM→COUNT on a window tick.
- COUNT→ADJUST on a window tick.
- ADJUST→COUNT after one cycle.
- COUNT/ADJUST→ARM when the reference select changes.
- Any state→IDLE when the enable drops.

Top module: `dfll_calibrator`

## Requirements
- R1: After reset the calibration code is CODE_INIT (64 with the default 7-bit code).
- R2: A measurement window spans exactly 32 rising edges of the selected reference. Its count equals the number of oscillator cycles in that span, with no off-by-one error. A target one above or one below the count therefore steps the code.
- R3: When the window count is above the target, the code decreases by one after that window.
- R4: When the window count is below the target, the code increases by one after that window. The code never moves by more than one per cycle.
- R5: When the window count equals the target, the code is unchanged.
- R6: The code saturates at 0 and at 2^CODE_W-1 (127) and never wraps.
- R7: ref_sel_i = 0 selects ref_int_i and ref_sel_i = 1 selects ref_xtal_i. A change of select while enabled discards the window in progress.
- R8: While enable_i is low, counting stops and the code holds, whatever the references or the target do.
- R9: After enable rises or the select changes, the first window is discarded. The code changes only in the cycle after ST_ADJUST.
- R10: In a closed loop with an oscillator whose frequency rises with the code, the code settles within 5 steps of the lowest code that meets the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Clock of the oscillator under calibration |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Calibration run enable |
| ref_sel_i | input | 1 | Reference select: 0 internal, 1 crystal |
| ref_int_i | input | 1 | Internal calibrated 32.768 kHz reference, asynchronous |
| ref_xtal_i | input | 1 | Crystal 32.768 kHz reference, asynchronous |
| expected_i | input | CNT_W | Target oscillator cycles per window |
| cal_code_o | output | CODE_W | Calibration code driven to the oscillator |

## Verification
The window tick trails the 32nd synchronised reference edge by about four oscillator cycles. The code changes two cycles after the tick, so the exact time of an adjustment depends on the reference phase. The bench therefore samples the code half a window after the point where a tick is due. After enable or a select change, it checks at 48 reference periods that nothing has changed yet. It then checks once per further window at the same mid-window offset, where the expected number of steps is fixed. The closed-loop trials are given thousands of cycles and are checked against a tolerance band around the lock code that the bench computes.

// File: rtl/dfll_pkg.sv
package dfll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_COUNT,
        ST_ADJUST
    } cal_state_t;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_UP,
        STEP_DOWN
    } step_dir_t;

    localparam int unsigned NUM_REF = 2;

endpackage

// File: rtl/dfll_ref_sync.sv
module dfll_ref_sync #(
    parameter int unsigned N_REF  = 2,
    parameter int unsigned STAGES = 2,
    localparam int unsigned SEL_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_REF-1:0] ref_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             edge_o
);

    logic [N_REF-1:0] synced;
    logic             sel_lvl;
    logic             prev_q;

    for (genvar g = 0; g < N_REF; g++) begin : g_sync
        logic [STAGES-1:0] pipe_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                pipe_q <= '0;
            end else begin
                pipe_q <= {pipe_q[STAGES-2:0], ref_i[g]};
            end
        end
        assign synced[g] = pipe_q[STAGES-1];
    end

    assign sel_lvl = synced[sel_i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sel_lvl;
        end
    end

    assign edge_o = sel_lvl & ~prev_q;

    AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_o |=> !edge_o); // R2

endmodule

// File: rtl/dfll_ref_divider.sv
module dfll_ref_divider #(
    parameter int unsigned DIV = 32,
    localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic edge_i,
    output logic tick_o
);

    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] edges_q;
    logic          tick_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            edges_q <= '0;
            tick_q  <= 1'b0;
        end else if (clear_i) begin
            edges_q <= '0;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= edge_i && (edges_q == LAST);
            if (edge_i) begin
                edges_q <= (edges_q == LAST) ? '0 : edges_q + 1'b1;
            end
        end
    end

    assign tick_o = tick_q;

    AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R2

endmodule

// File: rtl/dfll_period_counter.sv
module dfll_period_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] meas_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            meas_o <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            meas_o <= cnt_inc;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_inc;
        end
    end

    AST_HOLD_MEAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> $stable(meas_o)); // R8

endmodule

// File: rtl/dfll_code_stepper.sv
module dfll_code_stepper
    import dfll_pkg::*;
#(
    parameter int unsigned CODE_W    = 7,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned CODE_INIT = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              apply_i,
    input  logic [CNT_W-1:0]  meas_i,
    input  logic [CNT_W-1:0]  expected_i,
    output logic [CODE_W-1:0] code_o
);

    localparam logic [CODE_W-1:0] CODE_MAX   = '1;
    localparam logic [CODE_W-1:0] CODE_RESET = CODE_W'(CODE_INIT);

    step_dir_t         dir;
    logic [CODE_W-1:0] code_q;

    always_comb begin
        if (meas_i > expected_i) begin
            dir = STEP_DOWN;
        end else if (meas_i < expected_i) begin
            dir = STEP_UP;
        end else begin
            dir = STEP_HOLD;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            code_q <= CODE_RESET;
        end else if (apply_i) begin
            unique case (dir)
                STEP_UP:   if (code_q != CODE_MAX) code_q <= code_q + 1'b1;
                STEP_DOWN: if (code_q != '0)       code_q <= code_q - 1'b1;
                default:   code_q <= code_q;
            endcase
        end
    end

    assign code_o = code_q;

    AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (apply_i && (meas_i > expected_i) && (code_q != '0))
        |=> (code_q == $past(code_q) - 1'b1)); // R3
    AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (code_q != $past(code_q)) |->
        ((code_q == $past(code_q) + 1'b1) || (code_q == $past(code_q) - 1'b1))); // R4
    AST_EQUAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (apply_i && (meas_i == expected_i)) |=> $stable(code_q)); // R5
    AST_NO_WRAP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(code_q) == '0) |-> (code_q != CODE_MAX)); // R6
    AST_NO_WRAP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(code_q) == CODE_MAX) |-> (code_q != '0)); // R6

endmodule

// File: rtl/dfll_calibrator.sv
module dfll_calibrator
    import dfll_pkg::*;
#(
    parameter int unsigned CODE_W    = 7,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned REF_DIV   = 32,
    parameter int unsigned SYNC_LEN  = 2,
    parameter int unsigned CODE_INIT = 64
) (
    input  logic              osc_clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              ref_sel_i,
    input  logic              ref_int_i,
    input  logic              ref_xtal_i,
    input  logic [CNT_W-1:0]  expected_i,
    output logic [CODE_W-1:0] cal_code_o
);

    cal_state_t       state_q;
    cal_state_t       state_d;
    logic             sel_q;
    logic             sel_chg;
    logic             ref_edge;
    logic             tick;
    logic             run;
    logic             div_clear;
    logic             apply;
    logic [CNT_W-1:0] meas;
    logic [NUM_REF-1:0] ref_vec;

    assign ref_vec = {ref_xtal_i, ref_int_i};
    assign sel_chg = (ref_sel_i != sel_q);

    always_ff @(posedge osc_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= ref_sel_i;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!enable_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_ARM;
                ST_ARM:    state_d = (tick && !sel_chg) ? ST_COUNT : ST_ARM;
                ST_COUNT:  state_d = sel_chg ? ST_ARM : (tick ? ST_ADJUST : ST_COUNT);
                ST_ADJUST: state_d = sel_chg ? ST_ARM : ST_COUNT;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        run       = (state_q != ST_IDLE);
        div_clear = !run || sel_chg;
        apply     = (state_q == ST_ADJUST) && enable_i;
    end

    dfll_ref_sync #(
        .N_REF  (NUM_REF),
        .STAGES (SYNC_LEN)
    ) u_sync (
        .clk_i  (osc_clk_i),
        .rst_ni (rst_ni),
        .ref_i  (ref_vec),
        .sel_i  (ref_sel_i),
        .edge_o (ref_edge)
    );

    dfll_ref_divider #(
        .DIV (REF_DIV)
    ) u_div (
        .clk_i   (osc_clk_i),
        .rst_ni  (rst_ni),
        .clear_i (div_clear),
        .edge_i  (ref_edge),
        .tick_o  (tick)
    );

    dfll_period_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i  (osc_clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .tick_i (tick),
        .meas_o (meas)
    );

    dfll_code_stepper #(
        .CODE_W    (CODE_W),
        .CNT_W     (CNT_W),
        .CODE_INIT (CODE_INIT)
    ) u_step (
        .clk_i      (osc_clk_i),
        .rst_ni     (rst_ni),
        .apply_i    (apply),
        .meas_i     (meas),
        .expected_i (expected_i),
        .code_o     (cal_code_o)
    );

    AST_DISABLED_HOLD: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        !enable_i |=> $stable(cal_code_o)); // R8
    AST_ADJUST_FROM_COUNT: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        (state_q == ST_ADJUST) |-> ($past(state_q) == ST_COUNT)); // R9
    AST_CHANGE_AFTER_ADJUST: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        (cal_code_o != $past(cal_code_o)) |-> ($past(state_q) == ST_ADJUST)); // R9
    AST_SELECT_REARMS: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        (enable_i && sel_chg && (state_q != ST_IDLE)) |=> (state_q == ST_ARM)); // R7

endmodule

// File: tb/dfll_calibrator_bench.sv
module dfll_calibrator_bench;

    localparam int CODE_W = 7;
    localparam int CNT_W  = 16;
    localparam int MAXC   = (1 << CODE_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             sel = 1'b0;
    logic             ref0 = 1'b0;
    logic             ref1 = 1'b0;
    logic [CNT_W-1:0] expv = '0;
    logic [CODE_W-1:0] code;

    int per0 = 10;
    int per1 = 6;
    bit closed_loop = 1'b0;
    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int exp_code = 64;

    dfll_calibrator u_dfll_calibrator (
        .osc_clk_i  (clk),
        .rst_ni     (rst_n),
        .enable_i   (en),
        .ref_sel_i  (sel),
        .ref_int_i  (ref0),
        .ref_xtal_i (ref1),
        .expected_i (expv),
        .cal_code_o (code)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 195000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 195000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic int model_period(int c);
        return 4 + (c >> 2);
    endfunction

    function automatic int step_code(int c, int m, int dir);
        int r = c;
        for (int i = 0; i < m; i++) begin
            r = r + dir;
            if (r < 0) r = 0;
            if (r > MAXC) r = MAXC;
        end
        return r;
    endfunction

    function automatic int lock_code(int e);
        for (int c = 0; c <= MAXC; c++) begin
            if (32 * model_period(c) >= e) return c;
        end
        return MAXC;
    endfunction

    initial begin
        forever begin
            int p;
            p = closed_loop ? model_period(int'(code)) : per0;
            repeat (p / 2) @(negedge clk);
            ref0 = 1'b1;
            repeat (p - p / 2) @(negedge clk);
            ref0 = 1'b0;
        end
    end

    initial begin
        forever begin
            int p;
            p = per1;
            repeat (p / 2) @(negedge clk);
            ref1 = 1'b1;
            repeat (p - p / 2) @(negedge clk);
            ref1 = 1'b0;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int act, int expd);
        vectors = vectors + 1;
        if (act != expd) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, expd);
        end
    endtask

    // Called right after enable rises or the select changes.
    task automatic measure(int start, int m, int period, int dir, string req);
        wait_cyc(48 * period);
        check({req, " R9 first window discarded"}, int'(code), start);
        wait_cyc(m * 32 * period);
        exp_code = step_code(start, m, dir);
        check(req, int'(code), exp_code);
    endtask

    initial begin
        void'($urandom(32'd2024));
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 reset code", int'(code), 64);

        // R8: disabled, references toggling, target far away
        expv = 16'd0;
        wait_cyc(2000);
        check("R8 disabled hold", int'(code), 64);

        // R5: exact match, count = 32*10 = 320
        expv = 16'd320;
        en = 1'b1;
        measure(64, 3, 10, 0, "R5 equal hold");
        en = 1'b0;
        wait_cyc(40);

        expv = 16'd319;
        en = 1'b1;
        measure(exp_code, 3, 10, -1, "R2 R3 count above target");
        en = 1'b0;
        wait_cyc(40);

        expv = 16'd321;
        en = 1'b1;
        measure(exp_code, 3, 10, 1, "R2 R4 count below target");

        // R8: drop enable mid-window, target moved far
        en = 1'b0;
        expv = 16'd0;
        wait_cyc(5 * 320);
        check("R8 hold after disable", int'(code), exp_code);

        // R7: internal source gives 320 > 256, crystal gives 192 < 256
        expv = 16'd256;
        sel = 1'b0;
        en = 1'b1;
        measure(exp_code, 2, 10, -1, "R7 internal reference");
        sel = 1'b1;
        measure(exp_code, 3, 6, 1, "R7 crystal reference after switch");
        en = 1'b0;
        sel = 1'b0;
        wait_cyc(40);

        // Constrained random windows on the internal source
        for (int it = 0; it < 3; it++) begin
            int p, d, m, dir;
            p = int'($urandom_range(14, 8));
            d = int'($urandom_range(6, 0)) - 3;
            m = int'($urandom_range(4, 1));
            dir = (d < 0) ? -1 : ((d > 0) ? 1 : 0);
            per0 = p;
            expv = CNT_W'(32 * p + d);
            wait_cyc(40);
            en = 1'b1;
            measure(exp_code, m, p, dir, "R2 R3 R4 R5 random window");
            en = 1'b0;
            wait_cyc(10);
        end

        // R10: closed loop with a code-dependent oscillator model
        closed_loop = 1'b1;
        for (int t = 0; t < 2; t++) begin
            int e, lc, diff;
            e = 32 * (18 + 2 * t) + int'($urandom_range(31, 1));
            expv = CNT_W'(e);
            en = 1'b1;
            wait_cyc(30000);
            lc = lock_code(e);
            diff = int'(code) - lc;
            if (diff < 0) diff = -diff;
            check("R10 closed-loop lock distance within 5", (diff <= 5) ? 1 : 0, 1);
        end
        en = 1'b0;
        closed_loop = 1'b0;
        per0 = 8;
        wait_cyc(40);

        // R6: saturation at both ends, count = 256 per window
        expv = 16'd1;
        en = 1'b1;
        wait_cyc(100 * 256);
        check("R6 floor reached", int'(code), 0);
        wait_cyc(4 * 256);
        check("R6 floor held without wrap", int'(code), 0);
        expv = 16'hFFFF;
        wait_cyc(135 * 256);
        check("R6 ceiling reached", int'(code), MAXC);
        wait_cyc(4 * 256);
        check("R6 ceiling held without wrap", int'(code), MAXC);
        en = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule